// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog timer with a small 32-bit register window: a configuration register and a read-only status register. The configuration can only be changed by a pair of writes. The first write opens the lock with one key value in bits 23:16, and the second write carries a second key and the new settings. Software services the watchdog by repeating this pair with a reload value. The commit restarts the countdown.

A selectable prescaler divides the clock into counting ticks. A 16-bit down-counter runs on these ticks. A threshold, derived from the full timer range, raises a one-cycle warning interrupt before expiry. When the count reaches zero, a reset request is raised and stays high until the block itself is reset.

Top module: `keyed_watchdog`

## Requirements
- R1: The configuration register is at offset 0x0 and the status register is at offset 0x8. Any other offset reads zero. The configuration reads back enable in bit 31, the warning select in bits 27:26, the divider select in bits 25:24, zero in bits 23:16 and the reload value in bits 15:0.
- R2: A write to offset 0x0 with key 0xBE in bits 23:16 opens the lock and changes no setting. Only the next write, if it goes to offset 0x0 with key 0xDC, applies bits 31, 27:26, 25:24 and 15:0. A lone 0xDC write while locked changes nothing.
- R3: After an opening write, a second write with any key other than 0xDC, or a write to any other offset, discards the sequence. The block locks again and the configuration is unchanged.
- R4: Bit 31 enables counting. A commit with bit 31 clear freezes the count.
- R5: The divider select picks the clock division: 0 divides by 1, 1 by 64, 2 by 4096 and 3 by 262144. The prescaler restarts at every commit, so the first decrement comes a full divided period after the commit.
- R6: The warning select s sets the threshold 65536 >> (s+1), which is 4096 for s = 3. A decrement that lands on the threshold gives a warn_irq pulse of one cycle, in the same cycle that the new count is visible. A count loaded at or below the threshold gives no pulse.
- R7: rst_req rises in the cycle after the count is zero with counting enabled. It then stays high through any later commit until rst_n is asserted.
- R8: Every commit loads the count with bits 15:0 of the committing write; this is the service operation. The count then falls by one per tick. Status bit 31 shows the enable and status bits 15:0 show the live count.
- R9: After reset the block is disabled and locked. The reload value and the count are 0xFFFF, both selects are 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Byte offset for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| warn_irq | output | 1 | One-cycle pre-expiry warning pulse |
| rst_req | output | 1 | Sticky reset request on expiry |

## Verification
The hardest cases to reach are the broken key sequences: an opening write followed by a write to the status offset, or by a wrong key, and a bare commit key while locked. The bench builds each case from back-to-back writes and then reads the configuration to show that nothing changed. Warning pulses need counts above the threshold, so reloads just above 4096 and 8192 are committed with the fastest divider. A reload just below the threshold shows that no pulse occurs. The bench reaches expiry with a short reload and then commits again, to show that the request stays high.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'hBE;
  localparam logic [7:0] KEY_COMMIT = 8'hDC;

  typedef enum logic {KS_LOCKED, KS_OPEN} ks_state_t;

  // log2 of the clock division for a divider select
  function automatic int unsigned wdk_div_log2(input logic [1:0] sel,
      input int unsigned l1, input int unsigned l2, input int unsigned l3);
    case (sel)
      2'd0:    return 0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

  // warning threshold: full range shifted down by select+1
  function automatic int unsigned wdk_warn_level(input logic [1:0] sel,
      input int unsigned cnt_w);
    return (32'd1 << cnt_w) >> (32'(sel) + 32'd1);
  endfunction
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       ctrl_hit,
  input  logic [7:0] key,
  output logic       commit
);
  ks_state_t state;

  assign commit = wr_en && ctrl_hit && (state == KS_OPEN) && (key == KEY_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= KS_LOCKED;
    else if (wr_en) begin
      if (state == KS_LOCKED)
        state <= (ctrl_hit && key == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
      else
        state <= KS_LOCKED;
    end
  end

  // R2: a commit always leaves the sequencer locked
  p_commit_relocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> state == KS_LOCKED);
  // R3: from locked, only an opening key at offset 0 opens
  p_open_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_LOCKED && !(wr_en && ctrl_hit && key == KEY_OPEN)) |=> state == KS_LOCKED);
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler #(
  parameter int PRE_W = 18,
  localparam int SH_W = $clog2(PRE_W + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [SH_W-1:0] sh,
  output logic            tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] limit;

  assign limit = (PRE_W'(1) << sh) - PRE_W'(1);
  assign tick  = run && (pre == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (restart || tick) pre <= '0;
    else if (run) pre <= pre + PRE_W'(1);
  end

  // R5: after a restart no tick follows at once unless the division is 1
  p_restart_delays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick || sh == '0));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] warn_lvl,
  output logic [CNT_W-1:0] cnt,
  output logic             warn,
  output logic             expire
);
  logic step;
  assign step = tick && !load && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '1;
      warn   <= 1'b0;
      expire <= 1'b0;
    end else begin
      if (load) cnt <= load_val;
      else if (step) cnt <= cnt - CNT_W'(1);
      warn   <= step && ((cnt - CNT_W'(1)) == warn_lvl);
      expire <= expire || (en && cnt == '0);
    end
  end

  // R6: a warning is only seen with the count at the threshold
  p_warn_at_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> cnt == warn_lvl);
  // R7: the reset request never drops
  p_expire_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> expire);
  // R4: disabled and not loaded means frozen
  p_frozen_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));
  // R8: each tick takes exactly one off a nonzero count
  p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 16,
  parameter int DIV_LOG2_1 = 6,
  parameter int DIV_LOG2_2 = 12,
  parameter int DIV_LOG2_3 = 18,
  localparam int PRE_W     = DIV_LOG2_3,
  localparam int SH_W      = $clog2(PRE_W + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              warn_irq,
  output logic              rst_req
);
  logic             ctrl_hit, stat_hit, commit, run, tick;
  logic             en_q;
  logic [1:0]       pwl_q, div_q;
  logic [CNT_W-1:0] reload_q, cnt, warn_lvl;
  logic [SH_W-1:0]  sh;
  logic             unused_bits;

  assign ctrl_hit    = (addr == ADDR_W'(0));
  assign stat_hit    = (addr == ADDR_W'(8));
  assign unused_bits = ^wdata[30:28];

  wdk_keyseq u_keyseq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_hit(ctrl_hit),
    .key(wdata[23:16]), .commit(commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pwl_q    <= 2'd0;
      div_q    <= 2'd0;
      reload_q <= '1;
    end else if (commit) begin
      en_q     <= wdata[31];
      pwl_q    <= wdata[27:26];
      div_q    <= wdata[25:24];
      reload_q <= wdata[CNT_W-1:0];
    end
  end

  assign sh       = SH_W'(wdk_div_log2(div_q, DIV_LOG2_1, DIV_LOG2_2, DIV_LOG2_3));
  assign warn_lvl = CNT_W'(wdk_warn_level(pwl_q, CNT_W));
  assign run      = en_q && (cnt != '0);

  wdk_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(commit), .sh(sh), .tick(tick));

  wdk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en_q), .load(commit),
    .load_val(wdata[CNT_W-1:0]), .tick(tick), .warn_lvl(warn_lvl),
    .cnt(cnt), .warn(warn_irq), .expire(rst_req));

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[31]          = en_q;
      rdata[27:26]       = pwl_q;
      rdata[25:24]       = div_q;
      rdata[CNT_W-1:0]   = reload_q;
    end else if (stat_hit) begin
      rdata[31]          = en_q;
      rdata[CNT_W-1:0]   = cnt;
    end
  end

  // R3: settings move only on a commit
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(reload_q) && $stable(en_q) && $stable(div_q) && $stable(pwl_q)));
  // R1: offsets other than 0x0 and 0x8 read zero
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_hit && !stat_hit) |-> rdata == 32'd0);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        warn_irq, rst_req;

  int checks = 0, errors = 0, warn_seen = 0;
  bit done = 0;

  // reference state
  int m_en, m_pwl, m_div, m_reload, m_cnt, m_pre, m_open, m_warn, m_rst;

  always #4 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .warn_irq(warn_irq), .rst_req(rst_req));

  function automatic int ratio(int d);
    int lg [4] = '{0, 6, 12, 18};
    return 1 << lg[d];
  endfunction

  function automatic int thr(int p);
    return 65536 / (2 << p);
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (addr == 4'd0) return {m_en[0], 3'b0, m_pwl[1:0], m_div[1:0], 8'h00, m_reload[15:0]};
    if (addr == 4'd8) return {m_en[0], 15'b0, m_cnt[15:0]};
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pwl = 0; m_div = 0; m_reload = 65535; m_cnt = 65535;
      m_pre = 0; m_open = 0; m_warn = 0; m_rst = 0;
    end else begin
      bit cm, tk, nw, nr;
      cm = 0;
      if (wr_en) begin
        if (m_open == 0) m_open = (addr == 0 && wdata[23:16] == 8'hBE) ? 1 : 0;
        else begin
          cm = (addr == 0 && wdata[23:16] == 8'hDC);
          m_open = 0;
        end
      end
      tk = (m_en != 0) && (m_cnt != 0) && (m_pre == ratio(m_div) - 1);
      nw = tk && !cm && (m_cnt - 1 == thr(m_pwl));
      nr = (m_rst != 0) || ((m_en != 0) && m_cnt == 0);
      if (cm) begin
        m_en = int'(wdata[31]); m_pwl = int'(wdata[27:26]); m_div = int'(wdata[25:24]);
        m_reload = int'(wdata[15:0]); m_cnt = m_reload; m_pre = 0;
      end else if (tk) begin
        m_cnt = m_cnt - 1; m_pre = 0;
      end else if (m_en != 0 && m_cnt != 0) m_pre = m_pre + 1;
      m_warn = nw; m_rst = nr;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R8 rdata vs model", rdata, exp_rdata());
      check("R6 warn_irq vs model", {31'b0, warn_irq}, m_warn);
      check("R7 rst_req vs model", {31'b0, rst_req}, m_rst);
      if (warn_irq) warn_seen++;
    end
  end

  function automatic logic [31:0] cw(bit en, int pwl, int dv, int rl, logic [7:0] key);
    return {en, 3'b0, pwl[1:0], dv[1:0], key, rl[15:0]};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 4'd8;
  endtask

  task automatic commit_cfg(bit en, int pwl, int dv, int rl);
    wr(4'd0, cw(en, pwl, dv, rl, 8'hBE));
    wr(4'd0, cw(en, pwl, dv, rl, 8'hDC));
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3); rst_n = 1; idle(1);
    // R9 reset state
    rd(4'd0, v); check("R9 ctrl after reset", v, 32'h0000FFFF);
    rd(4'd8, v); check("R9 status after reset", v, 32'h0000FFFF);
    check("R9 outputs low", {30'b0, warn_irq, rst_req}, 32'd0);
    // R1 unmapped offsets
    rd(4'd4, v);  check("R1 offset 4 reads zero", v, 32'd0);
    rd(4'd12, v); check("R1 offset 12 reads zero", v, 32'd0);
    // R2 opening write alone, lone commit key
    wr(4'd0, cw(1, 1, 1, 100, 8'hBE));
    rd(4'd0, v); check("R2 open write applies nothing", v, 32'h0000FFFF);
    wr(4'd0, cw(1, 1, 1, 100, 8'h00));
    wr(4'd0, cw(1, 1, 1, 100, 8'hDC));
    rd(4'd0, v); check("R2 lone commit key ignored", v, 32'h0000FFFF);
    commit_cfg(1, 1, 0, 100);
    rd(4'd0, v); check("R2 R1 committed readback", v, 32'h84000064);
    idle(20);
    // R8 service reload
    commit_cfg(1, 1, 0, 50);
    rd(4'd8, v); check("R8 ping reloads count", v, 32'h80000031);
    // R4 stop
    commit_cfg(0, 0, 0, 40);
    rd(4'd8, v); idle(10); rd(4'd8, v2);
    check("R4 frozen when disabled", v2, v);
    check("R4 status enable clear", v2, 32'h00000028);
    // R3 broken sequences
    wr(4'd0, cw(1, 3, 2, 77, 8'hBE));
    wr(4'd8, 32'd0);
    wr(4'd0, cw(1, 3, 2, 77, 8'hDC));
    rd(4'd0, v); check("R3 intervening write discards", v, 32'h00000028);
    wr(4'd0, cw(1, 3, 2, 77, 8'hBE));
    wr(4'd0, cw(1, 3, 2, 77, 8'h55));
    wr(4'd0, cw(1, 3, 2, 77, 8'hDC));
    rd(4'd0, v); check("R3 wrong key discards", v, 32'h00000028);
    // R5 divide by 64 with prescaler restart
    commit_cfg(1, 0, 1, 10);
    rd(4'd8, v); check("R5 no early tick", v, 32'h8000000A);
    idle(61);
    rd(4'd8, v); check("R5 still full before 64", v, 32'h8000000A);
    rd(4'd8, v); check("R5 first step at 64", v, 32'h80000009);
    // R5 divide by 4096
    commit_cfg(1, 0, 2, 3);
    idle(4094);
    rd(4'd8, v); check("R5 div4096 before step", v, 32'h80000003);
    rd(4'd8, v); check("R5 div4096 step", v, 32'h80000002);
    // R5 divide by 262144
    commit_cfg(1, 0, 3, 1);
    idle(1000);
    rd(4'd8, v); check("R5 div262144 holds", v, 32'h80000001);
    // R6 warnings
    commit_cfg(1, 3, 0, 4100);
    warn_seen = 0; idle(20);
    check("R6 one pulse at 4096", warn_seen, 1);
    commit_cfg(1, 2, 0, 8200);
    warn_seen = 0; idle(20);
    check("R6 one pulse at 8192", warn_seen, 1);
    commit_cfg(1, 3, 0, 3000);
    warn_seen = 0; idle(20);
    check("R6 no pulse below level", warn_seen, 0);
    // R7 expiry
    commit_cfg(1, 0, 0, 5);
    idle(10);
    check("R7 expired", {31'b0, rst_req}, 32'd1);
    commit_cfg(1, 0, 0, 100);
    idle(3);
    check("R7 held across commit", {31'b0, rst_req}, 32'd1);
    @(negedge clk); rst_n = 0; #1;
    check("R9 R7 reset clears request", {31'b0, rst_req}, 32'd0);
    idle(2); rst_n = 1;
    rd(4'd8, v); check("R9 status after second reset", v, 32'h0000FFFF);
    idle(2);
    finish_run();
  end
endmodule